// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between a set of free-running internally generated clocks and the output pads. It gives an orderly shutdown and restart of those clocks under the control of one shared active-low pin. Right after power-up, the pin is read only as a power-good indication. The first time the synchronized pin is seen high, the sequencer turns the oscillator and PLL enables on. From then on, the same pin is read as a power-down request.

A request must be seen low on two consecutive rising edges of the CPU reference clock before it counts. When it counts, every output is stopped in its low phase by its own clock domain. Single-ended outputs are then either driven low or floated, depending on a strap. Both legs of each differential pair are held low. The oscillator and PLL enables drop only after every domain has reported that it is held.

On release, the enables come back first. The outputs stay stopped until the PLL lock input is high. Each output then restarts on its own clock with a full first pulse. A three-bit status output shows the current phase of the sequence.

Top module: `clkpd_seq_top`

## Requirements
- R1: After reset, the status is INIT (0), `osc_en` and `pll_en` are low and all clock outputs are low. While the synchronized pin has never been seen high, a low pin does nothing.
- R2: The shared pin goes through a two-flop synchronizer on `cpu_clk`. If the pin rises between edges, the status moves from INIT to WAIT_LOCK (4) on the third following `cpu_clk` rising edge, and `osc_en`/`pll_en` rise on that same edge.
- R3: Power-down is recognized only when the synchronized pin is low on two consecutive `cpu_clk` edges. From RUN, a pin low held from between two edges gives status STOPPING (2) on the fourth edge. A pin low for a single cycle has no effect.
- R4: Every high pulse on every clock output lasts exactly one half period of its source. There are no shortened pulses when stopping or restarting.
- R5: While running, `diff_out_c` is the complement of `diff_out_t`. In POWERED_DOWN (3), both legs of every pair are low.
- R6: While running, `se_oe` is all ones. When stopped, `se_oe` is all ones with `strap_float`=0 (outputs driven low) and all zeros with `strap_float`=1 (outputs floated).
- R7: `osc_en` and `pll_en` stay high throughout STOPPING. They fall only when the status becomes POWERED_DOWN, at which point every output is already held.
- R8: On release from POWERED_DOWN, the status becomes WAIT_LOCK with the enables high after three edges. All outputs stay stopped until `pll_lock` is high. RUN (1) follows three edges after lock rises. Each output's first rising edge comes at least four and at most seven of its own periods, plus 32 ns, after lock.
- R9: Losing `pll_lock` while in RUN neither changes the status nor stops the outputs.
- R10: Status encoding: INIT=0, RUN=1, STOPPING=2, POWERED_DOWN=3, WAIT_LOCK=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU reference clock that runs the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| se_src_clk | input | N_SE | Free-running sources for the single-ended outputs |
| diff_src_clk | input | N_DIFF | Free-running sources for the differential outputs |
| pgood_pd_n | input | 1 | Shared pin: power-good first, then active-low power-down request |
| strap_float | input | 1 | 1: float single-ended outputs when stopped; 0: drive them low |
| pll_lock | input | 1 | PLL lock indication (asynchronous) |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| se_clk_out | output | N_SE | Gated single-ended clocks |
| se_oe | output | N_SE | Output enables for the single-ended pads |
| diff_out_t | output | N_DIFF | Gated true legs |
| diff_out_c | output | N_DIFF | Gated complement legs |
| seq_state | output | 3 | Sequencer status (encoding in R10) |

## Verification
The assertions assume the following about the inputs:
- Every source clock keeps toggling during stopping and restart, because the per-domain synchronizers and restart counters advance only on those edges.
- `strap_float` does not change while outputs are stopped.
- The pin and lock inputs change away from `cpu_clk` rising edges.

The stimulus keeps within these assumptions as follows:
- The pin, lock and strap inputs are driven only on `cpu_clk` falling edges.
- Strap is changed only while the sequencer is waiting for lock.
- Every source is left running at a fixed half period for the whole run.

// File: rtl/clkpd_pkg.sv
`timescale 1ns/1ps
package clkpd_pkg;
  typedef enum logic [2:0] {
    SEQ_INIT = 3'd0,
    SEQ_RUN  = 3'd1,
    SEQ_STOP = 3'd2,
    SEQ_DOWN = 3'd3,
    SEQ_WAIT = 3'd4
  } seq_state_e;
endpackage

// File: rtl/clkpd_sync.sv
`timescale 1ns/1ps
module clkpd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/clkpd_gate.sv
`timescale 1ns/1ps
module clkpd_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int RESTART_CYC = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic en_hi,
  output logic en_lo,
  output logic active
);
  localparam int CNT_W = $clog2(RESTART_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RESTART_CYC);

  logic             run_s;
  logic [CNT_W-1:0] cnt_q;

  clkpd_sync #(.STAGES(SYNC_STAGES), .W(1)) run_sync_i (
    .clk(src_clk), .rst_n(rst_n), .d_in(run_req), .q_out(run_s)
  );

  // count own cycles after the request arrives, saturating
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_s)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // true-leg enable changes only while the source is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en_hi <= 1'b0;
    else        en_hi <= run_s && (cnt_q == CNT_MAX);
  end

  // complement-leg enable changes only while the source is high
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo  <= 1'b0;
      active <= 1'b0;
    end else begin
      en_lo  <= en_hi;
      active <= run_s | en_hi | en_lo;
    end
  end

  assert_restart_after_count_R8: assert property (
    @(posedge src_clk) disable iff (!rst_n)
    $rose(en_hi) |-> (run_s && cnt_q == CNT_MAX));

  assert_no_restart_without_run_R4: assert property (
    @(posedge src_clk) disable iff (!rst_n)
    (!run_s && !en_hi) |=> !en_hi);
endmodule

// File: rtl/clkpd_ctrl.sv
`timescale 1ns/1ps
module clkpd_ctrl
  import clkpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_DOM       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             lock_raw,
  input  logic [N_DOM-1:0] act_raw,
  output logic             run_req,
  output logic             osc_en,
  output logic             pll_en,
  output seq_state_e       state
);
  logic             pin_s, lock_s, pin_prev, pd_hit;
  logic [N_DOM-1:0] act_s;
  seq_state_e       state_d;

  clkpd_sync #(.STAGES(SYNC_STAGES), .W(2)) in_sync_i (
    .clk(clk), .rst_n(rst_n), .d_in({lock_raw, pin_raw}), .q_out({lock_s, pin_s})
  );

  clkpd_sync #(.STAGES(SYNC_STAGES), .W(N_DOM)) act_sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(act_raw), .q_out(act_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_s;
  end

  assign pd_hit = !pin_s && !pin_prev;

  always_comb begin
    state_d = state;
    unique case (state)
      SEQ_INIT: if (pin_s)                 state_d = SEQ_WAIT;
      SEQ_WAIT: if (pd_hit)                state_d = SEQ_STOP;
                else if (lock_s)           state_d = SEQ_RUN;
      SEQ_RUN:  if (pd_hit && (&act_s))    state_d = SEQ_STOP;
      SEQ_STOP: if (act_s == '0)           state_d = SEQ_DOWN;
      SEQ_DOWN: if (pin_s)                 state_d = SEQ_WAIT;
      default:                             state_d = SEQ_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_INIT;
      run_req <= 1'b0;
      osc_en  <= 1'b0;
      pll_en  <= 1'b0;
    end else begin
      state   <= state_d;
      run_req <= (state_d == SEQ_RUN);
      osc_en  <= (state_d == SEQ_WAIT) || (state_d == SEQ_RUN) || (state_d == SEQ_STOP);
      pll_en  <= (state_d == SEQ_WAIT) || (state_d == SEQ_RUN) || (state_d == SEQ_STOP);
    end
  end

  assert_init_quiet_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == SEQ_INIT) |-> (!osc_en && !pll_en && !run_req));

  assert_pd_two_lows_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == SEQ_STOP && $past(state) == SEQ_RUN) |-> (!$past(pin_s) && !$past(pin_s, 2)));

  assert_osc_off_after_hold_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (act_s == '0));

  assert_run_needs_lock_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(run_req) |-> $past(lock_s));

  assert_lock_loss_ignored_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN && pin_s) |=> (state == SEQ_RUN));
endmodule

// File: rtl/clkpd_seq_top.sv
`timescale 1ns/1ps
module clkpd_seq_top
  import clkpd_pkg::*;
#(
  parameter int N_SE        = 2,
  parameter int N_DIFF      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RESTART_CYC = 2
) (
  input  logic              cpu_clk,
  input  logic              rst_n,
  input  logic [N_SE-1:0]   se_src_clk,
  input  logic [N_DIFF-1:0] diff_src_clk,
  input  logic              pgood_pd_n,
  input  logic              strap_float,
  input  logic              pll_lock,
  output logic              osc_en,
  output logic              pll_en,
  output logic [N_SE-1:0]   se_clk_out,
  output logic [N_SE-1:0]   se_oe,
  output logic [N_DIFF-1:0] diff_out_t,
  output logic [N_DIFF-1:0] diff_out_c,
  output logic [2:0]        seq_state
);
  localparam int N_DOM = N_SE + N_DIFF;

  logic             run_req;
  logic [N_DOM-1:0] dom_act;
  seq_state_e       state_w;

  clkpd_ctrl #(.SYNC_STAGES(SYNC_STAGES), .N_DOM(N_DOM)) ctrl_i (
    .clk(cpu_clk), .rst_n(rst_n), .pin_raw(pgood_pd_n), .lock_raw(pll_lock),
    .act_raw(dom_act), .run_req(run_req), .osc_en(osc_en), .pll_en(pll_en),
    .state(state_w)
  );

  assign seq_state = state_w;

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic en_hi, en_lo;
    clkpd_gate #(.SYNC_STAGES(SYNC_STAGES), .RESTART_CYC(RESTART_CYC)) gate_i (
      .src_clk(se_src_clk[i]), .rst_n(rst_n), .run_req(run_req),
      .en_hi(en_hi), .en_lo(en_lo), .active(dom_act[i])
    );
    assign se_clk_out[i] = se_src_clk[i] & en_hi;
    // pad keeps driving low for half a cycle after the stop before floating
    assign se_oe[i]      = en_hi | en_lo | ~strap_float;
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_diff
    logic en_hi, en_lo;
    clkpd_gate #(.SYNC_STAGES(SYNC_STAGES), .RESTART_CYC(RESTART_CYC)) gate_i (
      .src_clk(diff_src_clk[j]), .rst_n(rst_n), .run_req(run_req),
      .en_hi(en_hi), .en_lo(en_lo), .active(dom_act[N_SE + j])
    );
    assign diff_out_t[j] =  diff_src_clk[j] & en_hi;
    assign diff_out_c[j] = ~diff_src_clk[j] & en_lo;
  end

  assert_diff_low_when_down_R5: assert property (
    @(posedge cpu_clk) disable iff (!rst_n)
    (state_w == SEQ_DOWN) |-> (diff_out_t == '0 && diff_out_c == '0));

  assert_oe_follows_strap_R6: assert property (
    @(posedge cpu_clk) disable iff (!rst_n)
    (state_w == SEQ_DOWN) |-> (se_oe == (strap_float ? '0 : '1) && se_clk_out == '0));
endmodule

// File: tb/clkpd_seq_top_tb_top.sv
`timescale 1ns/1ps
module clkpd_pulse_mon #(parameter longint HALF_PS = 5000) (
  input  logic   sig,
  input  logic   arm,
  output int     runts,
  output int     pulses,
  output longint first_ps,
  output logic   got
);
  longint t_rise = 0;
  logic   armed  = 1'b0;
  initial begin runts = 0; pulses = 0; first_ps = 0; got = 1'b0; end
  always @(posedge arm) begin armed = 1'b1; got = 1'b0; end
  always @(posedge sig) begin
    t_rise = longint'($realtime * 1000.0);
    if (armed) begin first_ps = t_rise; armed = 1'b0; got = 1'b1; end
  end
  always @(negedge sig) begin
    pulses = pulses + 1;
    if (longint'($realtime * 1000.0) - t_rise != HALF_PS) runts = runts + 1;
  end
endmodule

module clkpd_seq_top_tb_top;
  logic       cpu_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] se_src = 2'b00, diff_src = 2'b00;
  logic       pin = 1'b0, strap = 1'b0, lock = 1'b0, arm = 1'b0;
  logic       osc_en, pll_en;
  logic [1:0] se_out, se_oe, d_t, d_c;
  logic [2:0] st;

  int     n_chk = 0, n_bad = 0;
  bit     done = 1'b0;
  int     runts[6], pulses[6];
  longint first_ps[6];
  logic [5:0] got;
  localparam longint HALF_NS[6] = '{5, 7, 6, 9, 6, 9};

  always #4   cpu_clk     = ~cpu_clk;
  always #5   se_src[0]   = ~se_src[0];
  always #7   se_src[1]   = ~se_src[1];
  always #6   diff_src[0] = ~diff_src[0];
  always #9   diff_src[1] = ~diff_src[1];

  clkpd_seq_top dut_i (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .se_src_clk(se_src), .diff_src_clk(diff_src),
    .pgood_pd_n(pin), .strap_float(strap), .pll_lock(lock), .osc_en(osc_en),
    .pll_en(pll_en), .se_clk_out(se_out), .se_oe(se_oe), .diff_out_t(d_t),
    .diff_out_c(d_c), .seq_state(st)
  );

  clkpd_pulse_mon #(.HALF_PS(5000)) m0 (.sig(se_out[0]), .arm(arm), .runts(runts[0]), .pulses(pulses[0]), .first_ps(first_ps[0]), .got(got[0]));
  clkpd_pulse_mon #(.HALF_PS(7000)) m1 (.sig(se_out[1]), .arm(arm), .runts(runts[1]), .pulses(pulses[1]), .first_ps(first_ps[1]), .got(got[1]));
  clkpd_pulse_mon #(.HALF_PS(6000)) m2 (.sig(d_t[0]),    .arm(arm), .runts(runts[2]), .pulses(pulses[2]), .first_ps(first_ps[2]), .got(got[2]));
  clkpd_pulse_mon #(.HALF_PS(9000)) m3 (.sig(d_t[1]),    .arm(arm), .runts(runts[3]), .pulses(pulses[3]), .first_ps(first_ps[3]), .got(got[3]));
  clkpd_pulse_mon #(.HALF_PS(6000)) m4 (.sig(d_c[0]),    .arm(arm), .runts(runts[4]), .pulses(pulses[4]), .first_ps(first_ps[4]), .got(got[4]));
  clkpd_pulse_mon #(.HALF_PS(9000)) m5 (.sig(d_c[1]),    .arm(arm), .runts(runts[5]), .pulses(pulses[5]), .first_ps(first_ps[5]), .got(got[5]));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input longint act,
                         input longint lo, input longint hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int bad_cnt;
    longint lock_ps;
    int p_before[6];
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    // R1 R10: reset state
    chk("R10", "status after reset", st, 0);
    chk("R1", "osc_en after reset", osc_en, 0);
    chk("R1", "pll_en after reset", pll_en, 0);
    chk("R1", "outputs after reset", {se_out, d_t, d_c}, 0);
    chk("R6", "se_oe strap0 reset", se_oe, 3);
    cyc(20);
    chk("R1", "status with pin low", st, 0);
    // R2: first high is power-good
    pin = 1'b1;
    cyc(2);
    chk("R2", "status after 2 edges", st, 0);
    cyc(1);
    chk("R2", "status after 3 edges", st, 4);
    chk("R2", "osc_en with wait", osc_en & pll_en, 1);

    for (int it = 0; it < 4; it++) begin
      strap = it[0];
      // R8: stopped until lock
      bad_cnt = 0;
      for (int k = 0; k < (it[1] ? 30 : 3); k++) begin
        cyc(1);
        if ({se_out, d_t, d_c} != 0 || st != 4) bad_cnt++;
      end
      chk("R8", "outputs held before lock", bad_cnt, 0);
      arm = 1'b1;
      lock = 1'b1;
      lock_ps = longint'($realtime * 1000.0);
      cyc(2);
      chk("R8", "status 2 edges after lock", st, 4);
      cyc(1);
      chk("R10", "status RUN after lock", st, 1);
      for (int k = 0; k < 80 && got != 6'h3f; k++) cyc(1);
      arm = 1'b0;
      for (int o = 0; o < 4; o++)
        chk_rng("R8", $sformatf("first rise delay out%0d", o), first_ps[o] - lock_ps,
                8000 * HALF_NS[o], 32000 + 14000 * HALF_NS[o]);
      cyc(10);
      chk("R6", "se_oe while running", se_oe, 3);
      bad_cnt = 0;
      for (int k = 0; k < 20; k++) begin
        #1.5;
        if (d_c != ~d_t) bad_cnt++;
        cyc(1);
      end
      chk("R5", "complement legs while running", bad_cnt, 0);
      // R9: lock loss ignored
      for (int o = 0; o < 6; o++) p_before[o] = pulses[o];
      lock = 1'b0;
      cyc(50);
      chk("R9", "status after lock loss", st, 1);
      bad_cnt = 0;
      for (int o = 0; o < 6; o++) if (pulses[o] - p_before[o] < 5) bad_cnt++;
      chk("R9", "outputs kept running", bad_cnt, 0);
      lock = 1'b1;
      // R3: single-cycle glitch ignored
      pin = 1'b0;
      cyc(1);
      pin = 1'b1;
      cyc(20);
      chk("R3", "status after 1-cycle low", st, 1);
      // R3: qualified request
      pin = 1'b0;
      cyc(3);
      chk("R3", "status after 3 edges low", st, 1);
      cyc(1);
      chk("R3", "status after 4 edges low", st, 2);
      // R7: enables stay high while stopping
      bad_cnt = 0;
      for (int k = 0; k < 60 && st == 2; k++) begin
        if (!osc_en || !pll_en) bad_cnt++;
        cyc(1);
      end
      chk("R7", "enables high during stopping", bad_cnt, 0);
      chk("R7", "status reaches powered down", st, 3);
      chk("R7", "enables low when down", {osc_en, pll_en}, 0);
      chk("R5", "all outputs low when down", {se_out, d_t, d_c}, 0);
      chk("R6", "se_oe when down", se_oe, strap ? 0 : 3);
      lock = 1'b0;
      bad_cnt = 0;
      for (int k = 0; k < 30; k++) begin
        cyc(1);
        if ({se_out, d_t, d_c} != 0 || st != 3 || osc_en) bad_cnt++;
      end
      chk("R5", "outputs held while down", bad_cnt, 0);
      // R8: release brings enables first
      pin = 1'b1;
      cyc(2);
      chk("R8", "status 2 edges after release", st, 3);
      cyc(1);
      chk("R8", "status 3 edges after release", st, 4);
      chk("R8", "enables after release", {osc_en, pll_en}, 3);
    end

    for (int o = 0; o < 6; o++) begin
      chk("R4", $sformatf("short pulses out%0d", o), runts[o], 0);
      chk_rng("R4", $sformatf("pulse count out%0d", o), pulses[o], 40, 1_000_000);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule